// File: doc/BRIEF.md
# Complementary Output Safe-State Controller

This block sits between one PWM channel and the two pins it feeds: a main pin and a complementary pin. Each pin has a level and a drive enable, and the enable releases the pin (tri-state) when it is low. In normal running, the controller passes the channel reference to the main pin and its inverse to the complementary pin. A per-pin polarity bit is applied to each, and a pin whose enable bit is clear is released.

The controller owns the master output enable. Software sets or clears it with a write strobe. A fault input clears it, and it then stays clear until software writes a 1 while the synchronized fault is low. When the master enable is clear, or while the fault input is high, the controller is in the off-state. As soon as the fault input rises, and with no clock edge needed, each pin takes the level of its own polarity bit. A two-flop synchronized copy of the fault then clears the master enable and loads a dead-time counter, which counts down once per clock. When the counter reaches zero, each pin moves to its programmed idle level. An off-state select chooses whether the pins are driven or released during the off-state. A channel with both pin enables clear is released completely.

Idle levels are normally programmed to the inactive level of each pin. When both pins are unused, the polarity and idle bits are expected to be zero.

Top module: `comp_out_guard`

## Requirements
- R1: When mainEn and compEn are both 0, mainOe and compOe are 0 and both pin levels are 0 (polarity and idle bits held at 0), whatever the fault, master-enable and off-select state.
- R2: While the master enable is set and faultIn is low, an enabled main pin drives refIn XOR mainPol and an enabled complementary pin drives (NOT refIn) XOR compPol, each with its drive enable at 1. A pin whose enable bit is 0 has its drive enable at 0.
- R3: While faultIn is high, at least one enable is set and the idle level is not yet applied, mainPin equals mainPol and compPin equals compPol in the same cycle. No clock edge is needed.
- R4: The master enable is cleared at the third rising clock edge after faultIn rises (two synchronizer flops, then the update). A write of 1 is ignored while the synchronized fault is high. Once the fault has been low for two edges, a write of 1 restores normal running at the write's clock edge.
- R5: The off-state is entered at edge E, and deadTime holds D at that edge. The pins then hold their polarity levels for D cycles, and from edge E+D onward mainPin equals mainIdle and compPin equals compIdle. When D is 0, the idle levels apply from edge E.
- R6: A write of 0 to the master enable while it is set enters the off-state at that write's edge, with the same dead-time sequence as R5.
- R7: In the off-state with at least one enable set, both drive enables equal offSel. This holds even for a pin whose own enable bit is 0.
- R8: During and after reset, the master enable is clear and the off-state has already settled, so the pins show their idle levels with drive enables equal to offSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| refIn | input | 1 | Raw channel reference from the PWM generator |
| mainEn | input | 1 | Main pin enable |
| compEn | input | 1 | Complementary pin enable |
| mainPol | input | 1 | Main pin polarity (1 inverts) |
| compPol | input | 1 | Complementary pin polarity (1 inverts) |
| mainIdle | input | 1 | Main pin idle level |
| compIdle | input | 1 | Complementary pin idle level |
| offSel | input | 1 | Off-state select: 1 drives pins, 0 releases them |
| moeWrEn | input | 1 | Master enable write strobe |
| moeWrVal | input | 1 | Master enable write value |
| faultIn | input | 1 | Asynchronous fault, active high |
| deadTime | input | DT_W (8) | Dead-time count loaded on off-state entry |
| mainPin | output | 1 | Main pin level |
| mainOe | output | 1 | Main pin drive enable |
| compPin | output | 1 | Complementary pin level |
| compOe | output | 1 | Complementary pin drive enable |

## Verification
The embedded assertions check on every cycle that an unused channel is released and that an active fault forces polarity levels with the drive enables set by offSel. They also check that a synchronized fault or a software clear reloads the dead-time counter, that the counter steps down by one, and that no write can restore running during a fault. Some behaviour shows only in the bench's scenarios: the exact edge at which the idle levels appear for several dead-time values, the edge at which the master enable clears, and the return to running after the fault drops. The bench sweeps every legal combination of reference, enables and polarities in running mode. It then repeats the fault sequence across both off-select settings and several dead-time values.

// File: rtl/cog_pkg.sv
package cog_pkg;
  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned PIN_MAIN = 0;
  localparam int unsigned PIN_COMP = 1;

  // Strobes from the control to the pin datapath
  typedef struct packed {
    logic offActive;  // master enable clear
    logic idleNow;    // dead-time elapsed, idle levels apply
  } cog_strobe_t;
endpackage

// File: rtl/cog_ctrl.sv
module cog_ctrl
  import cog_pkg::*;
#(
  parameter int unsigned DT_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            faultIn,
  input  logic            moeWrEn,
  input  logic            moeWrVal,
  input  logic [DT_W-1:0] deadTime,
  output cog_strobe_t     strobes
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] syncQ;
  logic             faultSync;
  logic             faultRise;
  logic             masterOn;
  logic [DT_W-1:0]  dtCnt;
  logic             swClear;
  logic             swSet;

  // Synchronizer chain plus one edge-detect stage
  for (genvar s = 0; s < int'(CHAIN); s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= faultIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  assign faultSync = syncQ[SYNC_STAGES-1];
  assign faultRise = faultSync & ~syncQ[SYNC_STAGES];
  assign swClear   = masterOn & moeWrEn & ~moeWrVal;
  assign swSet     = moeWrEn & moeWrVal & ~faultSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterOn <= 1'b0;
      dtCnt    <= '0;
    end else if (faultRise || swClear) begin
      masterOn <= 1'b0;
      dtCnt    <= deadTime;
    end else if (swSet) begin
      masterOn <= 1'b1;
      dtCnt    <= '0;
    end else if (!masterOn && dtCnt != '0) begin
      dtCnt <= dtCnt - DT_W'(1);
    end
  end

  assign strobes.offActive = ~masterOn;
  assign strobes.idleNow   = ~masterOn & (dtCnt == '0);

  assert_fault_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultRise |=> (!masterOn && dtCnt == $past(deadTime)));

  assert_no_wake_in_fault_R4: assert property (@(posedge clk) disable iff (!rstN)
    faultSync |=> !masterOn);

  assert_dt_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!masterOn && dtCnt != '0 && !faultRise && !moeWrEn) |=> (dtCnt == $past(dtCnt) - DT_W'(1)));

  assert_sw_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (masterOn && moeWrEn && !moeWrVal) |=> (!masterOn && dtCnt == $past(deadTime)));
endmodule

// File: rtl/cog_path.sv
module cog_path
  import cog_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                refIn,
  input  logic [NUM_PINS-1:0] pinEn,
  input  logic [NUM_PINS-1:0] pinPol,
  input  logic [NUM_PINS-1:0] pinIdle,
  input  logic                offSel,
  input  logic                faultIn,
  input  cog_strobe_t         strobes,
  output logic [NUM_PINS-1:0] pinLvl,
  output logic [NUM_PINS-1:0] pinOe
);
  logic anyEn;
  logic forceOff;

  assign anyEn    = |pinEn;
  assign forceOff = faultIn | strobes.offActive;

  for (genvar i = 0; i < int'(NUM_PINS); i++) begin : g_pin
    logic runLvl;
    logic lvl;
    logic oe;

    if (i == int'(PIN_COMP)) begin : g_comp
      assign runLvl = ~refIn ^ pinPol[i];
    end else begin : g_main
      assign runLvl = refIn ^ pinPol[i];
    end

    always_comb begin
      if (!anyEn) begin
        lvl = pinPol[i];
        oe  = 1'b0;
      end else if (strobes.idleNow) begin
        lvl = pinIdle[i];
        oe  = offSel;
      end else if (forceOff) begin
        lvl = pinPol[i];
        oe  = offSel;
      end else if (pinEn[i]) begin
        lvl = runLvl;
        oe  = 1'b1;
      end else begin
        lvl = pinPol[i];
        oe  = 1'b0;
      end
    end

    assign pinLvl[i] = lvl;
    assign pinOe[i]  = oe;
  end

  assert_unused_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pinEn == '0) |-> (pinOe == '0));

  assert_fault_polarity_R3: assert property (@(posedge clk) disable iff (!rstN)
    (faultIn && anyEn && !strobes.idleNow) |-> (pinLvl == pinPol));

  assert_off_drive_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.offActive && anyEn) |-> (pinOe == {NUM_PINS{offSel}}));
endmodule

// File: rtl/comp_out_guard.sv
module comp_out_guard
  import cog_pkg::*;
#(
  parameter int unsigned DT_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refIn,
  input  logic            mainEn,
  input  logic            compEn,
  input  logic            mainPol,
  input  logic            compPol,
  input  logic            mainIdle,
  input  logic            compIdle,
  input  logic            offSel,
  input  logic            moeWrEn,
  input  logic            moeWrVal,
  input  logic            faultIn,
  input  logic [DT_W-1:0] deadTime,
  output logic            mainPin,
  output logic            mainOe,
  output logic            compPin,
  output logic            compOe
);
  cog_strobe_t         strobes;
  logic [NUM_PINS-1:0] pinLvl;
  logic [NUM_PINS-1:0] pinOe;

  cog_ctrl #(.DT_W(DT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .faultIn  (faultIn),
    .moeWrEn  (moeWrEn),
    .moeWrVal (moeWrVal),
    .deadTime (deadTime),
    .strobes  (strobes)
  );

  cog_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .pinEn   ({compEn, mainEn}),
    .pinPol  ({compPol, mainPol}),
    .pinIdle ({compIdle, mainIdle}),
    .offSel  (offSel),
    .faultIn (faultIn),
    .strobes (strobes),
    .pinLvl  (pinLvl),
    .pinOe   (pinOe)
  );

  assign mainPin = pinLvl[PIN_MAIN];
  assign mainOe  = pinOe[PIN_MAIN];
  assign compPin = pinLvl[PIN_COMP];
  assign compOe  = pinOe[PIN_COMP];
endmodule

// File: tb/sim_comp_out_guard.sv
module sim_comp_out_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0, mainEn = 1'b1, compEn = 1'b1;
  logic mainPol = 1'b0, compPol = 1'b0, mainIdle = 1'b1, compIdle = 1'b1;
  logic offSel = 1'b1, moeWrEn = 1'b0, moeWrVal = 1'b0, faultIn = 1'b0;
  logic [7:0] deadTime = 8'd0;
  logic mainPin, mainOe, compPin, compOe;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  comp_out_guard u0 (
    .clk(clk), .rstN(rstN), .refIn(refIn), .mainEn(mainEn), .compEn(compEn),
    .mainPol(mainPol), .compPol(compPol), .mainIdle(mainIdle), .compIdle(compIdle),
    .offSel(offSel), .moeWrEn(moeWrEn), .moeWrVal(moeWrVal), .faultIn(faultIn),
    .deadTime(deadTime), .mainPin(mainPin), .mainOe(mainOe), .compPin(compPin),
    .compOe(compOe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Compare {mainPin, mainOe, compPin, compOe}
  task automatic chk(input string tag, input logic [3:0] expv);
    logic [3:0] act;
    #1;
    act = {mainPin, mainOe, compPin, compOe};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  task automatic wrMoe(input logic v);
    moeWrEn = 1'b1;
    moeWrVal = v;
    tick();
    moeWrEn = 1'b0;
  endtask

  function automatic logic [3:0] polExp();
    return {mainPol, offSel, compPol, offSel};
  endfunction

  function automatic logic [3:0] idleExp();
    return {mainIdle, offSel, compIdle, offSel};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R8: reset state settles to idle levels, drive = offSel
    tick();
    chk("R8 during reset", 4'b1111);
    offSel = 1'b0;
    chk("R8 during reset offSel=0", 4'b1010);
    offSel = 1'b1;
    tick();
    rstN = 1'b1;
    tick();
    chk("R8 after reset", 4'b1111);

    // R2 and R1: running sweep
    wrMoe(1'b1);
    for (int en = 0; en < 4; en++) begin
      for (int pl = 0; pl < 4; pl++) begin
        for (int r = 0; r < 2; r++) begin
          logic [3:0] e;
          if (en == 0 && pl != 0) continue;
          mainEn = en[0]; compEn = en[1];
          mainPol = pl[0]; compPol = pl[1];
          mainIdle = (en == 0) ? 1'b0 : 1'b1;
          compIdle = mainIdle;
          refIn = r[0];
          e[3] = mainEn ? (refIn ^ mainPol) : mainPol;
          e[2] = mainEn;
          e[1] = compEn ? (~refIn ^ compPol) : compPol;
          e[0] = compEn;
          if (en == 0) chk("R1 released while running", 4'b0000);
          else         chk("R2 running output", e);
        end
      end
    end

    // R3, R4, R5, R7: fault sequence across offSel and dead-time values
    for (int os = 0; os < 2; os++) begin
      for (int k = 0; k < 3; k++) begin
        int d;
        d = (k == 0) ? 0 : ((k == 1) ? 1 : 4);
        mainEn = 1'b1; compEn = 1'b1; refIn = 1'b1;
        offSel = os[0];
        mainPol = d[0]; compPol = ~d[0];
        mainIdle = ~mainPol; compIdle = ~compPol;
        deadTime = 8'(d);
        chk("R2 running before fault", {refIn ^ mainPol, 1'b1, ~refIn ^ compPol, 1'b1});
        faultIn = 1'b1;
        chk("R3 immediate polarity on fault", polExp());
        tick();
        tick();
        chk("R3 polarity held before sync", polExp());
        tick();  // entry edge
        if (d == 0) chk("R5 idle at entry with zero dead-time", idleExp());
        else        chk("R5 polarity at entry", polExp());
        for (int j = 1; j <= d; j++) begin
          tick();
          if (j < d) chk("R5 polarity during dead-time", polExp());
          else       chk("R5 idle after dead-time", idleExp());
        end
        wrMoe(1'b1);
        chk("R4 write ignored during fault", idleExp());
        faultIn = 1'b0;
        tick(); tick(); tick();
        chk("R4 stays off after fault drops", idleExp());
        wrMoe(1'b1);
        chk("R4 running restored by write", {refIn ^ mainPol, 1'b1, ~refIn ^ compPol, 1'b1});
      end
    end

    // R6: software clear with dead-time 2
    offSel = 1'b1; mainPol = 1'b0; compPol = 1'b1; mainIdle = 1'b1; compIdle = 1'b0;
    deadTime = 8'd2; refIn = 1'b1;
    wrMoe(1'b0);
    chk("R6 polarity at write edge", polExp());
    tick();
    chk("R6 polarity one cycle later", polExp());
    tick();
    chk("R6 idle after dead-time", idleExp());
    wrMoe(1'b1);

    // R7: one pin enabled, both driven under fault
    mainEn = 1'b1; compEn = 1'b0; offSel = 1'b1; deadTime = 8'd50;
    chk("R2 disabled comp released", {refIn ^ mainPol, 1'b1, compPol, 1'b0});
    faultIn = 1'b1;
    chk("R7 both driven in off-state", polExp());
    tick(); tick(); tick();
    offSel = 1'b0;
    chk("R7 both released with offSel=0", polExp());

    // R1: unused channel under fault
    mainEn = 1'b0; compEn = 1'b0; mainPol = 1'b0; compPol = 1'b0;
    mainIdle = 1'b0; compIdle = 1'b0; offSel = 1'b1;
    chk("R1 released under fault", 4'b0000);
    faultIn = 1'b0;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule